// File: doc/BRIEF.md
# Late Branch Resolver with Pipeline Redirect

This block sits beside the ALU stage of a pipelined 8-bit processor core and settles conditional relative branches there. Fetch always assumes a branch falls through, so the fetch PC simply moves past the 2-byte branch. When the branch reaches the ALU stage, the block compares one status flag, chosen by the opcode, against the polarity the opcode demands. If the branch falls through, the block does nothing.

If the branch is taken, the block registers the decision. On the next cycle it raises a one-cycle redirect. The redirect invalidates the four younger stages (operand fetch, pointer prefetch, decode and fetch), empties the instruction byte queue, and loads a new PC. The new PC is the branch address plus 2 plus the sign-extended 8-bit displacement. The instruction that enters the ALU stage during the redirect cycle is younger than the branch, so the block ignores it.

Top module: `branch_resolve`

## Requirements
- R1: An opcode is a conditional branch only when its low five bits equal 5'b10000. Any other opcode never causes a redirect, whatever the flags are.
- R2: Opcode bits 7:6 pick the flag to test: 00 selects N, 01 selects V, 10 selects C and 11 selects Z. `status_i` carries N, V, C and Z in bits 3, 2, 1 and 0. The branch is taken when the selected flag equals opcode bit 5, so 8'h10 is taken when N is clear.
- R3: A taken branch with `valid_i` high in cycle t makes `pc_load_o` high in cycle t+1, for that one cycle only.
- R4: `queue_flush_o` and all four bits of `kill_o` are high in exactly the cycles where `pc_load_o` is high. The bits of `kill_o` map to stages as follows: bit 0 is operand fetch, bit 1 is pointer prefetch, bit 2 is decode and bit 3 is fetch.
- R5: Alongside `pc_load_o`, `pc_target_o` equals pc_i + 2 + sign_extend(disp_i), taken modulo 2^16.
- R6: A branch that is not taken, or any cycle with `valid_i` low, produces no redirect, no kill and no flush in the following cycle.
- R7: A branch presented in a cycle where `pc_load_o` is high is ignored. No redirect follows it, and `pc_target_o` keeps its value.
- R8: While reset is held, every output is zero.
- R9: `pc_target_o` holds the most recent taken target until the next accepted taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | The ALU stage holds a live instruction |
| opcode_i | input | 8 | Opcode of the instruction in the ALU stage |
| status_i | input | 4 | Flags: N in bit 3, V in bit 2, C in bit 1, Z in bit 0 |
| pc_i | input | 16 | Address of the instruction in the ALU stage |
| disp_i | input | 8 | Signed relative displacement |
| pc_load_o | output | 1 | Load `pc_target_o` into the fetch PC |
| pc_target_o | output | 16 | Redirect address |
| kill_o | output | 4 | Invalidate the younger stages |
| queue_flush_o | output | 1 | Empty the instruction byte queue |

## Verification
The hardest case to reach from the ports is a second taken branch arriving in the very cycle that the redirect from the first is presented. It only happens when `valid_i` stays high on two consecutive taken branches. The bench drives exactly that back-to-back pair and checks three things: no second redirect follows, the first target survives, and a later branch is accepted again. Every combination of the 256 opcodes and the 16 flag patterns is also swept, with addresses chosen so that some sums wrap past 16'hFFFF.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    SEL_N = 2'd0,
    SEL_V = 2'd1,
    SEL_C = 2'd2,
    SEL_Z = 2'd3
  } flag_sel_e;

  typedef struct packed {
    logic n;
    logic v;
    logic c;
    logic z;
  } status_t;

  localparam logic [4:0] REL_BRANCH_LOW = 5'b10000;

  function automatic logic is_rel_branch(input logic [7:0] op);
    return op[4:0] == REL_BRANCH_LOW;
  endfunction
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  status_t    status_i,
  output logic       hit_o
);
  flag_sel_e sel;
  logic      flag;

  assign sel = flag_sel_e'(opcode_i[7:6]);

  always_comb begin
    unique case (sel)
      SEL_N:   flag = status_i.n;
      SEL_V:   flag = status_i.v;
      SEL_C:   flag = status_i.c;
      default: flag = status_i.z;
    endcase
  end

  assign hit_o = is_rel_branch(opcode_i) && (flag == opcode_i[5]);
endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
  parameter int PC_W     = 16,
  parameter int DISP_W   = 8,
  parameter int INSN_LEN = 2
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [PC_W-1:0]   target_o
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] next_pc;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign next_pc  = pc_i + PC_W'(INSN_LEN);
  assign target_o = next_pc + disp_ext;
endmodule

// File: rtl/brc_flush_fanout.sv
module brc_flush_fanout #(
  parameter int N_KILL = 4
) (
  input  logic              redirect_i,
  output logic [N_KILL-1:0] kill_o,
  output logic              flush_o
);
  for (genvar g = 0; g < N_KILL; g++) begin : g_kill
    assign kill_o[g] = redirect_i;
  end
  assign flush_o = redirect_i;
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import brc_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int DISP_W   = 8,
  parameter int INSN_LEN = 2,
  parameter int N_KILL   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [3:0]        status_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   pc_target_o,
  output logic [N_KILL-1:0] kill_o,
  output logic              queue_flush_o
);
  logic            hit;
  logic            accept;
  logic            redirect_q;
  logic [PC_W-1:0] target_d;
  logic [PC_W-1:0] target_q;

  brc_cond_eval u_cond (
    .opcode_i (opcode_i),
    .status_i (status_t'(status_i)),
    .hit_o    (hit)
  );

  brc_target_calc #(
    .PC_W     (PC_W),
    .DISP_W   (DISP_W),
    .INSN_LEN (INSN_LEN)
  ) u_target (
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .target_o (target_d)
  );

  // ALU-stage occupant during a redirect is younger than the branch: drop it
  assign accept = valid_i && hit && !redirect_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q <= 1'b0;
      target_q   <= '0;
    end else begin
      redirect_q <= accept;
      if (accept) target_q <= target_d;
    end
  end

  brc_flush_fanout #(
    .N_KILL (N_KILL)
  ) u_fanout (
    .redirect_i (redirect_q),
    .kill_o     (kill_o),
    .flush_o    (queue_flush_o)
  );

  assign pc_load_o   = redirect_q;
  assign pc_target_o = target_q;
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int N_KILL = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        opcode_i,
  input logic [3:0]        status_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [DISP_W-1:0] disp_i,
  input logic              pc_load_o,
  input logic [PC_W-1:0]   pc_target_o,
  input logic [N_KILL-1:0] kill_o,
  input logic              queue_flush_o
);
  logic cond_met;
  assign cond_met = (opcode_i[4:0] == 5'b10000) &&
                    (status_i[3 - opcode_i[7:6]] == opcode_i[5]);

  p_nonbranch_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i[4:0] != 5'b10000) |=> !pc_load_o);

  p_taken_redirects_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_met && !pc_load_o) |=> pc_load_o);

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);

  p_kill_with_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> (kill_o == {N_KILL{1'b1}}) && queue_flush_o);

  p_no_kill_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_load_o |-> (kill_o == '0) && !queue_flush_o);

  p_target_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_met && !pc_load_o) |=>
      pc_target_o == PC_W'($past(pc_i) + PC_W'(2) +
                     {{(PC_W-DISP_W){$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

  p_idle_no_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !pc_load_o);

  p_shadow_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> $stable(pc_target_o));

  p_target_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && cond_met) |=> $stable(pc_target_o));
endmodule

bind branch_resolve brc_checker #(
  .PC_W   (PC_W),
  .DISP_W (DISP_W),
  .N_KILL (N_KILL)
) u_brc_checker (.*);

// File: tb/branch_resolve_test.sv
`timescale 1ns/1ps
module branch_resolve_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [3:0]  status_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  disp_i = '0;
  logic        pc_load_o;
  logic [15:0] pc_target_o;
  logic [3:0]  kill_o;
  logic        queue_flush_o;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_target = '0;

  always #10 clk_i = ~clk_i;

  branch_resolve uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [7:0] op, input logic [3:0] st);
    if (op[4:0] != 5'b10000) return 1'b0;
    return st[3 - op[7:6]] == op[5];
  endfunction

  function automatic logic [15:0] calc_target(input logic [15:0] pc,
                                              input logic [7:0] d);
    int s;
    s = (d >= 128) ? int'(d) - 256 : int'(d);
    return 16'((int'(pc) + 2 + s) & 16'hFFFF);
  endfunction

  task automatic check_outputs(input bit taken, input string req);
    chk(pc_load_o == taken, req, {31'd0, pc_load_o}, {31'd0, taken});
    chk(kill_o == {4{taken}} && queue_flush_o == taken, "R4",
        {27'd0, queue_flush_o, kill_o}, {27'd0, taken, {4{taken}}});
    chk(pc_target_o == exp_target, taken ? "R5" : "R9",
        {16'd0, pc_target_o}, {16'd0, exp_target});
  endtask

  // present one instruction, then one idle cycle
  task automatic issue(input logic [7:0] op, input logic [3:0] st,
                       input logic [15:0] pc, input logic [7:0] d, input string req);
    bit t;
    t = exp_taken(op, st);
    valid_i = 1'b1; opcode_i = op; status_i = st; pc_i = pc; disp_i = d;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (t) exp_target = calc_target(pc, d);
    check_outputs(t, req);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R8: outputs during reset
    chk(pc_load_o == 0 && kill_o == 0 && queue_flush_o == 0 && pc_target_o == 0,
        "R8", {11'd0, pc_load_o, kill_o, queue_flush_o, pc_target_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_outputs(1'b0, "R8");

    // R1, R2, R5, R6, R9: full opcode x flag sweep
    for (int op = 0; op < 256; op++) begin
      for (int st = 0; st < 16; st++) begin
        issue(8'(op), 4'(st), 16'(op * 257 + st * 4099), 8'(op ^ (st * 17)),
              (op % 32 == 16) ? "R2" : "R1");
      end
    end

    // R5: wrap-around boundaries (BPL with N clear)
    issue(8'h10, 4'h0, 16'hFFFE, 8'h7F, "R5");
    issue(8'h10, 4'h0, 16'h0001, 8'h80, "R5");
    issue(8'h10, 4'h0, 16'hFFFD, 8'h01, "R5");
    // R6: valid low never redirects even with a taken condition present
    valid_i = 1'b0; opcode_i = 8'h10; status_i = 4'h0; pc_i = 16'h4000; disp_i = 8'h10;
    @(negedge clk_i);
    check_outputs(1'b0, "R6");

    // R3, R7: back-to-back taken branches
    valid_i = 1'b1; opcode_i = 8'hF0; status_i = 4'h1; pc_i = 16'h1000; disp_i = 8'h20;
    @(negedge clk_i);
    exp_target = 16'h1022;
    check_outputs(1'b1, "R3");
    opcode_i = 8'h90; status_i = 4'h0; pc_i = 16'h2000; disp_i = 8'h04;
    @(negedge clk_i);
    valid_i = 1'b0;
    check_outputs(1'b0, "R7");
    @(negedge clk_i);
    check_outputs(1'b0, "R7");
    issue(8'h90, 4'h0, 16'h2000, 8'h04, "R3");
    chk(pc_target_o == 16'h2006, "R9", {16'd0, pc_target_o}, 32'h2006);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule